// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block is a 32-entry register file of 32-bit words that can be read and written at three widths. A single access touches one word. A double access touches an even/odd pair as one 64-bit value. A quad access touches four consecutive words, starting at an index that is a multiple of four, as one 128-bit value. All three views use the same storage, so a wide write changes every narrower register it covers, and a narrow write shows up inside every wider register that contains it.

The block has two independent read ports and one write port. Each port takes a register index and a two-bit size code. Writes are committed on the rising clock edge. Reads are combinational from the stored state, so a read and a write to the same storage in one cycle return the value from before the write. A request whose index does not fit the alignment of its size raises an error flag on that port. A failed write changes nothing, and a failed read returns zero. An active-low synchronous reset clears the whole file.

Top module: `multiwidth_regfile`

## Requirements
- R1: While rst_n is low at a rising clock edge, every one of the 32 words becomes zero. Reset takes priority over a write in the same cycle.
- R2: Size code 0 means single. A single write stores wr_data[31:0] into word wr_idx at the clock edge. A single read returns that word in bits 31:0 and zeros in bits 127:32.
- R3: Size code 1 means double. The lower-numbered word of the pair is in bits 31:0 and the higher-numbered word is in bits 63:32, for both reads and writes. Bits 127:64 of a double read are zero.
- R4: Size code 2 means quad. Word base+k is in bits 32k+31:32k for k = 0..3, for both reads and writes.
- R5: All views alias one storage. A wide write is visible through single reads of each word it covers, and a single write is visible inside the double and quad that contain it.
- R6: A port's error flag is combinational. It is 1 for a double with an odd index, for a quad whose index is not a multiple of four, and for the reserved size code 3. It is 0 for every single. wr_err can only be 1 while wr_en is 1.
- R7: A write that raises wr_err leaves all storage unchanged. A read that raises its error flag returns all zeros.
- R8: When a read and a write hit the same storage in one cycle, the read returns the value from before that cycle's edge.
- R9: The two read ports are independent. Each one returns its own index and size in the same cycle.
- R10: With wr_en low, storage does not change, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index (base of the group) |
| wr_size | input | 2 | Write size: 0 single, 1 double, 2 quad, 3 reserved |
| wr_data | input | 128 | Write data, lane k in bits 32k+31:32k |
| wr_err | output | 1 | Write alignment/size error, write suppressed |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 128 | Read port 0 data, unused lanes zero |
| rd0_err | output | 1 | Read port 0 alignment/size error |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 128 | Read port 1 data, unused lanes zero |
| rd1_err | output | 1 | Read port 1 alignment/size error |

## Verification
The error flags and the read data depend only on the port inputs and the stored state, so they are due in the same cycle as the stimulus. A write becomes visible on the read ports one edge later. The bench drives every input just after a falling edge and samples about 1 ns later, before the next rising edge. The reads in a vector therefore show the state from before that vector's own write, and the effect of that write is checked by the reads in the next vector. The reset tests sample after the rising edge on which rst_n was low.

// File: rtl/mrf_pkg.sv
// Package: shared size encoding and helpers for the multi-width register file.
// Assumes a maximum access width of four words.
package mrf_pkg;

    typedef enum logic [1:0] {
        SZ_SINGLE = 2'd0,
        SZ_DOUBLE = 2'd1,
        SZ_QUAD   = 2'd2,
        SZ_RSVD   = 2'd3
    } size_e;

    localparam int unsigned MAX_LANES = 4;

    // Number of words an access of the given size covers (0 for reserved).
    function automatic int unsigned lanes_of(input size_e sz);
        case (sz)
            SZ_SINGLE: lanes_of = 1;
            SZ_DOUBLE: lanes_of = 2;
            SZ_QUAD:   lanes_of = 4;
            default:   lanes_of = 0;
        endcase
    endfunction

endpackage

// File: rtl/mrf_align_chk.sv
// Module: alignment and size checker for one port.
// Flags a double with an odd index, a quad whose index is not a multiple of
// four, and the reserved size code. Purely combinational.
module mrf_align_chk
    import mrf_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output logic             misaligned
);

    // Decide whether the index fits the size.
    always_comb begin
        case (size_e'(size))
            SZ_SINGLE: misaligned = 1'b0;
            SZ_DOUBLE: misaligned = idx[0];
            SZ_QUAD:   misaligned = |idx[1:0];
            default:   misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/mrf_storage.sv
// Module: word storage with lane-steered writes.
// Each word decides for itself whether the current write covers it and which
// lane of the write data it takes. Assumes a qualified (error-free) commit.
module mrf_storage
    import mrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned BUS_W   = MAX_LANES * WORD_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [1:0]                       wr_size,
    input  logic [BUS_W-1:0]                 wr_data,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  file_q
);

    logic [WORD_W-1:0] wr_lane [MAX_LANES];

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        assign wr_lane[l] = wr_data[l*WORD_W +: WORD_W];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);
        logic              hit;
        logic [1:0]        lane;
        logic [WORD_W-1:0] word_q;

        // Work out whether this word is covered and by which lane.
        always_comb begin
            case (size_e'(wr_size))
                SZ_SINGLE: begin
                    hit  = (wr_idx == MY_IDX);
                    lane = 2'd0;
                end
                SZ_DOUBLE: begin
                    hit  = (wr_idx[IDX_W-1:1] == MY_IDX[IDX_W-1:1]);
                    lane = {1'b0, MY_IDX[0]};
                end
                SZ_QUAD: begin
                    hit  = (wr_idx[IDX_W-1:2] == MY_IDX[IDX_W-1:2]);
                    lane = MY_IDX[1:0];
                end
                default: begin
                    hit  = 1'b0;
                    lane = 2'd0;
                end
            endcase
        end

        // Hold the word; clear on reset, load its lane on a covering write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (commit && hit) begin
                word_q <= wr_lane[lane];
            end
        end

        assign file_q[r] = word_q;
    end

endmodule

// File: rtl/mrf_read_port.sv
// Module: one combinational read port.
// Gathers up to four consecutive words from the base index; lanes beyond
// the access size, and every lane of an erroneous request, read as zero.
module mrf_read_port
    import mrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned BUS_W   = MAX_LANES * WORD_W
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0]  file_q,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [1:0]                       size,
    output logic [BUS_W-1:0]                 data,
    output logic                             err
);

    mrf_align_chk #(.IDX_W(IDX_W)) u_chk (
        .idx        (idx),
        .size       (size),
        .misaligned (err)
    );

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        logic             lane_on;

        // Select the word for this lane, or zero when the lane is unused.
        always_comb begin
            lane_idx = idx + IDX_W'(l);
            lane_on  = (l < lanes_of(size_e'(size))) && !err;
            data[l*WORD_W +: WORD_W] = lane_on ? file_q[lane_idx] : '0;
        end
    end

endmodule

// File: rtl/multiwidth_regfile.sv
// Module: top of the multi-width aliased register file.
// One write port and two read ports, each with an index and size code.
// Writes commit at the rising edge unless flagged; reads are combinational
// and therefore return pre-edge contents. Assumes NUM_REGS is a power of two
// and a multiple of four.
module multiwidth_regfile
    import mrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned BUS_W   = MAX_LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [BUS_W-1:0] wr_data,
    output logic             wr_err,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_size,
    output logic [BUS_W-1:0] rd0_data,
    output logic             rd0_err,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_size,
    output logic [BUS_W-1:0] rd1_data,
    output logic             rd1_err
);

    logic                            wr_misaligned;
    logic                            commit;
    logic [NUM_REGS-1:0][WORD_W-1:0] file_q;

    mrf_align_chk #(.IDX_W(IDX_W)) u_wr_chk (
        .idx        (wr_idx),
        .size       (wr_size),
        .misaligned (wr_misaligned)
    );

    // Qualify the write: only an enabled, well-formed request commits.
    always_comb begin
        commit = wr_en && !wr_misaligned;
        wr_err = wr_en &&  wr_misaligned;
    end

    mrf_storage #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_idx  (wr_idx),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .file_q  (file_q)
    );

    mrf_read_port #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rd0 (
        .file_q (file_q),
        .idx    (rd0_idx),
        .size   (rd0_size),
        .data   (rd0_data),
        .err    (rd0_err)
    );

    mrf_read_port #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rd1 (
        .file_q (file_q),
        .idx    (rd1_idx),
        .size   (rd1_size),
        .data   (rd1_data),
        .err    (rd1_err)
    );

endmodule

// File: rtl/mrf_checker.sv
// Module: assertion checker bound to the register file top.
// Observes ports and the storage vector; drives nothing.
module mrf_checker
    import mrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned BUS_W   = MAX_LANES * WORD_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [1:0]                      wr_size,
    input logic [BUS_W-1:0]                wr_data,
    input logic                            wr_err,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic [1:0]                      rd0_size,
    input logic [BUS_W-1:0]                rd0_data,
    input logic                            rd0_err,
    input logic [NUM_REGS-1:0][WORD_W-1:0] file_q
);

    logic was_reset;

    // Remember that the previous edge saw reset, then check the file is clear.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
        if (was_reset) begin
            AST_RESET_CLEARS: assert (file_q == '0); // R1
        end
    end

    AST_SINGLE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0) |=> file_q[$past(wr_idx)] == $past(wr_data[WORD_W-1:0])); // R2

    AST_DOUBLE_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd1 && wr_idx[0]) |-> wr_err); // R6

    AST_QUAD_OFFSET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'd2 && rd0_idx[1:0] != 2'd0) |-> rd0_err); // R6

    AST_SINGLE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'd0) |-> !rd0_err); // R6

    AST_ERR_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(file_q)); // R7

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_err |-> rd0_data == '0); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(file_q)); // R10

endmodule

bind multiwidth_regfile mrf_checker #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_mrf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .wr_err   (wr_err),
    .rd0_idx  (rd0_idx),
    .rd0_size (rd0_size),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err),
    .file_q   (file_q)
);

// File: tb/tb_multiwidth_regfile.sv
// Bench: vector table walked by one loop, then directed reset and alignment tests.
module tb_multiwidth_regfile;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [4:0]   wr_idx;
    logic [1:0]   wr_size;
    logic [127:0] wr_data;
    logic         wr_err;
    logic [4:0]   rd0_idx;
    logic [1:0]   rd0_size;
    logic [127:0] rd0_data;
    logic         rd0_err;
    logic [4:0]   rd1_idx;
    logic [1:0]   rd1_size;
    logic [127:0] rd1_data;
    logic         rd1_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    multiwidth_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    typedef struct packed {
        logic         wen;
        logic [4:0]   widx;
        logic [1:0]   wsz;
        logic [127:0] wdata;
        logic         werr;
        logic [4:0]   r0i;
        logic [1:0]   r0s;
        logic [127:0] r0e;
        logic         r0err;
        logic [4:0]   r1i;
        logic [1:0]   r1s;
        logic [127:0] r1e;
        logic         r1err;
    } vec_t;

    localparam logic [127:0] ONES = {4{32'hFFFF_FFFF}};

    // Reads in each row show the state before that row's own write (R8).
    localparam vec_t VECS [11] = '{
        '{1'b1, 5'd5,  2'd0, 128'h1111_0005, 1'b0,
          5'd5,  2'd0, 128'h0, 1'b0,  5'd0,  2'd2, 128'h0, 1'b0},
        '{1'b1, 5'd6,  2'd1, 128'hAAAA_0007_AAAA_0006, 1'b0,
          5'd5,  2'd0, 128'h1111_0005, 1'b0,  5'd4,  2'd1, 128'h1111_0005_0000_0000, 1'b0},
        '{1'b1, 5'd8,  2'd2, 128'hC000_000B_C000_000A_C000_0009_C000_0008, 1'b0,
          5'd6,  2'd1, 128'hAAAA_0007_AAAA_0006, 1'b0,
          5'd4,  2'd2, 128'hAAAA_0007_AAAA_0006_1111_0005_0000_0000, 1'b0},
        '{1'b1, 5'd3,  2'd1, ONES, 1'b1,
          5'd8,  2'd2, 128'hC000_000B_C000_000A_C000_0009_C000_0008, 1'b0,
          5'd9,  2'd0, 128'hC000_0009, 1'b0},
        '{1'b0, 5'd0,  2'd0, 128'h0, 1'b0,
          5'd2,  2'd0, 128'h0, 1'b0,  5'd3,  2'd0, 128'h0, 1'b0},
        '{1'b1, 5'd6,  2'd2, ONES, 1'b1,
          5'd3,  2'd1, 128'h0, 1'b1,  5'd10, 2'd1, 128'hC000_000B_C000_000A, 1'b0},
        '{1'b1, 5'd0,  2'd3, ONES, 1'b1,
          5'd6,  2'd0, 128'hAAAA_0006, 1'b0,  5'd4,  2'd3, 128'h0, 1'b1},
        '{1'b0, 5'd29, 2'd1, ONES, 1'b0,
          5'd7,  2'd0, 128'hAAAA_0007, 1'b0,  5'd12, 2'd2, 128'h0, 1'b0},
        '{1'b1, 5'd31, 2'd0, 128'hDEAD_001F, 1'b0,
          5'd30, 2'd1, 128'h0, 1'b0,  5'd31, 2'd0, 128'h0, 1'b0},
        '{1'b1, 5'd9,  2'd0, 128'h5555_0009, 1'b0,
          5'd30, 2'd1, 128'hDEAD_001F_0000_0000, 1'b0,
          5'd28, 2'd2, 128'hDEAD_001F_0000_0000_0000_0000_0000_0000, 1'b0},
        '{1'b0, 5'd0,  2'd0, 128'h0, 1'b0,
          5'd8,  2'd2, 128'hC000_000B_C000_000A_5555_0009_C000_0008, 1'b0,
          5'd8,  2'd1, 128'h5555_0009_C000_0008, 1'b0}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_idx = '0; wr_size = '0; wr_data = '0;
        rd0_idx = '0; rd0_size = '0; rd1_idx = '0; rd1_size = '0;
    endtask

    // Read every quad through port 0 and compare with zero.
    task automatic check_all_zero(input string req);
        for (int q = 0; q < 8; q++) begin
            rd0_idx = 5'(q * 4); rd0_size = 2'd2;
            #0.5;
            check(req, rd0_data, 128'h0);
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all_zero("R1 reset state");

        // Table walk: covers R2, R3, R4, R5, R6, R7, R8, R9, R10.
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wen; wr_idx = VECS[i].widx; wr_size = VECS[i].wsz; wr_data = VECS[i].wdata;
            rd0_idx = VECS[i].r0i; rd0_size = VECS[i].r0s;
            rd1_idx = VECS[i].r1i; rd1_size = VECS[i].r1s;
            #1;
            check($sformatf("R2/R3/R4/R5/R8 row %0d port0 data", i), rd0_data, VECS[i].r0e);
            check($sformatf("R9 row %0d port1 data", i), rd1_data, VECS[i].r1e);
            check($sformatf("R6/R7 row %0d port0 err", i), 128'(rd0_err), 128'(VECS[i].r0err));
            check($sformatf("R6 row %0d port1 err", i), 128'(rd1_err), 128'(VECS[i].r1err));
            check($sformatf("R6/R7/R10 row %0d wr_err", i), 128'(wr_err), 128'(VECS[i].werr));
        end

        // R6: exhaustive alignment sweep on port 0 and the write port.
        @(negedge clk);
        idle_inputs();
        for (int ix = 0; ix < 32; ix++) begin
            for (int sz = 0; sz < 4; sz++) begin
                logic exp_e;
                exp_e = (sz == 3) || (sz == 1 && (ix % 2) != 0) || (sz == 2 && (ix % 4) != 0);
                rd0_idx = 5'(ix); rd0_size = 2'(sz);
                rd1_idx = 5'(ix); rd1_size = 2'(sz);
                wr_idx  = 5'(ix); wr_size  = 2'(sz);
                #0.05;
                check($sformatf("R6 sweep rd0 idx %0d size %0d", ix, sz), 128'(rd0_err), 128'(exp_e));
                check($sformatf("R6 sweep wr_err disabled idx %0d size %0d", ix, sz), 128'(wr_err), 128'(0));
            end
        end
        idle_inputs();

        // R1: reset takes priority over a concurrent write and clears the file.
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1; wr_idx = 5'd12; wr_size = 2'd2; wr_data = ONES;
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 0;
        #1;
        check_all_zero("R1 reset over write");

        // R4: quad write at the top group, lane order checked through singles (R5).
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd28; wr_size = 2'd2;
        wr_data = 128'h4444_0003_3333_0002_2222_0001_1111_0000;
        @(negedge clk);
        wr_en = 0;
        for (int k = 0; k < 4; k++) begin
            rd0_idx = 5'(28 + k); rd0_size = 2'd0;
            #0.5;
            check($sformatf("R4/R5 quad lane %0d", k), rd0_data,
                  128'(wr_data[k*32 +: 32]));
        end
        // R3: upper half of a double read is zero even when the file is full.
        rd1_idx = 5'd30; rd1_size = 2'd1;
        #0.5;
        check("R3 double upper zero", rd1_data, 128'h4444_0003_3333_0002);

        @(negedge clk);
        summary();
    end

endmodule